// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue

This block is the receive half of a fixed-format asynchronous serial port. It watches a single line, finds each start bit, samples the frame at fourteen sample ticks per bit and assembles eight data bits, least significant first, followed by one stop bit. There is no parity and there are no modem-control signals. The sample tick rate comes from the system clock divided by an 8-bit divisor plus one, so one bit lasts `(rate_div+1)*14` clock cycles. After reset the divisor should be programmed; the slowest setting is 0xFF.

Each finished frame goes into a 64-entry queue together with its framing and break flags. Software pops one word at a time through a read strobe. The word carries the byte, an empty marker and the two error flags, and a level output gives the current fill count. Five interrupt causes are available. Trigger level and inactivity timeout follow the queue state. Framing error, break and overrun are latched until a write-one-to-clear. Two enables gate the causes onto a single interrupt line.

Top module: `uart_rx_fifo`

## Requirements
- R1: After a synchronous reset, `level` is 0, `cause` is 0, `irq` is 0 and `rd_word` is 0.
- R2: A frame with a valid (high) stop bit is stored as one entry. `rd_word[7:0]` holds the byte, with the first data bit after the start bit in bit 0, and bits 10:8 are 0. One bit lasts `(rate_div+1)*14` clocks.
- R3: A pop while the queue is empty returns `rd_word` = 0x100: bit 8 is set and all other bits are 0. The level stays unchanged.
- R4: `level` counts the stored entries from 0 to 64. It rises by one for each stored frame and falls by one for each pop of a non-empty queue.
- R5: A frame whose stop bit is low and whose data is not all zero is stored with `rd_word[9]` set, and it latches `cause[2]`.
- R6: A frame whose data bits and stop bit are all low is a break. It is stored as byte 0x00 with `rd_word[10]` set and bit 9 clear, and it latches `cause[3]`.
- R7: A frame that completes while 64 entries are held is dropped and latches `cause[4]`. The level stays at 64 and the stored bytes are kept in order.
- R8: `cause[0]` is high while `level` is at or above the threshold set by `trig_sel`: codes 0 to 5 select 1, 4, 8, 16, 32 and 48 bytes, and codes 6 and 7 also select 48.
- R9: `cause[1]` is high when `tmo_sel` is not 0, the queue is not empty and no frame, pop or line activity has occurred for N character times. Codes 1, 2 and 3 give N = 4, 8 and 16, and one character is 140 sample ticks. A pop clears the cause. Code 0 never raises it.
- R10: Writing 1 on `err_clr[0]`, `err_clr[1]` or `err_clr[2]` clears `cause[2]`, `cause[3]` or `cause[4]` respectively. A zero in `err_clr` leaves the cause unchanged.
- R11: `irq` is registered one cycle after the causes. It equals (`rx_irq_en` AND (`cause[0]` OR `cause[1]`)) OR (`err_irq_en` AND (`cause[2]` OR `cause[3]` OR `cause[4]`)).
- R12: A low pulse on the line that is shorter than half a bit is rejected at the mid-bit check and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rate_div | input | 8 | Divisor; sample tick every rate_div+1 clocks |
| trig_sel | input | 3 | Receive trigger threshold code |
| tmo_sel | input | 2 | Inactivity timeout code |
| rx_irq_en | input | 1 | Enables trigger and timeout causes onto irq |
| err_irq_en | input | 1 | Enables framing, break and overrun causes onto irq |
| pop | input | 1 | Read strobe; pops one word |
| err_clr | input | 3 | Write-one-to-clear for framing, break, overrun |
| rd_word | output | 11 | Popped word: byte, empty, framing, break |
| level | output | 8 | Queue fill count |
| cause | output | 5 | Causes: trigger, timeout, framing, break, overrun |
| irq | output | 1 | Interrupt request |

## Verification
Reception is driven with a table of bytes that mixes alternating patterns, all-ones, all-zeros and single-edge bytes, with both good and bad stop bits. This separates a correct bit order and centre sampling from shifted or reversed capture, and it separates a framing error from a break, which differ only in the data content. Directed runs fill the queue to 64 and one beyond to show drop-on-full against overwrite. The trigger threshold is approached one byte at a time to catch off-by-one compares. The timeout is probed before and after its window. A short glitch shows that the mid-bit confirmation rejects false starts.

// File: rtl/urx_pkg.sv
package urx_pkg;
  localparam int OSR       = 14;
  localparam int MID_TICK  = 6;
  localparam int CHAR_TICKS = 10 * OSR;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  typedef struct packed {
    logic       brk;
    logic       fe;
    logic [7:0] data;
  } rx_entry_t;

  function automatic logic [6:0] trig_bytes(input logic [2:0] code);
    case (code)
      3'd0:    trig_bytes = 7'd1;
      3'd1:    trig_bytes = 7'd4;
      3'd2:    trig_bytes = 7'd8;
      3'd3:    trig_bytes = 7'd16;
      3'd4:    trig_bytes = 7'd32;
      default: trig_bytes = 7'd48;
    endcase
  endfunction
endpackage

// File: rtl/urx_sampler.sv
module urx_sampler
  import urx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_line,
  input  logic [DIV_W-1:0] rate_div,
  output logic             tick,
  output logic             idle,
  output logic             push,
  output rx_entry_t        entry
);
  logic             s1, s2, s_prev;
  logic [DIV_W-1:0] pre;
  logic [3:0]       scnt;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  rx_state_e        state;
  logic             start_det;

  assign start_det = (state == RX_IDLE) && s_prev && !s2;
  assign tick      = (pre == rate_div);
  assign idle      = (state == RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; s_prev <= 1'b1;
    end else begin
      s1 <= rx_line; s2 <= s1; s_prev <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start_det || tick) pre <= '0;
    else                          pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      scnt  <= '0;
      bitn  <= '0;
      sh    <= '0;
      push  <= 1'b0;
      entry <= '0;
    end else begin
      push <= 1'b0;
      case (state)
        RX_IDLE: if (start_det) begin
          state <= RX_START;
          scnt  <= '0;
        end
        RX_START: if (tick) begin
          if (scnt == 4'(MID_TICK)) begin
            scnt  <= '0;
            bitn  <= '0;
            state <= s2 ? RX_IDLE : RX_DATA;
          end else scnt <= scnt + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (scnt == 4'(OSR-1)) begin
            scnt <= '0;
            sh   <= {s2, sh[7:1]};
            if (bitn == 3'd7) state <= RX_STOP;
            else              bitn  <= bitn + 1'b1;
          end else scnt <= scnt + 1'b1;
        end
        default: if (tick) begin
          if (scnt == 4'(OSR-1)) begin
            scnt  <= '0;
            push  <= 1'b1;
            state <= RX_IDLE;
            if (!s2 && (sh == 8'h00)) entry <= '{brk: 1'b1, fe: 1'b0, data: 8'h00};
            else                      entry <= '{brk: 1'b0, fe: !s2, data: sh};
          end else scnt <= scnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo
  import urx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      push,
  input  rx_entry_t entry,
  input  logic      pop,
  output logic [10:0] rd_word,
  output logic [$clog2(DEPTH):0] count,
  output logic      ovr_evt
);
  localparam int AW = $clog2(DEPTH);

  rx_entry_t mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic full, empty, do_wr, do_rd;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_wr   = push && !full;
  assign do_rd   = pop && !empty;
  assign ovr_evt = push && full;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= entry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      rd_word <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      if (do_wr && !do_rd)      count <= count + 1'b1;
      else if (do_rd && !do_wr) count <= count - 1'b1;
      if (pop) begin
        if (empty) rd_word <= 11'h100;
        else       rd_word <= {mem[rptr].brk, mem[rptr].fe, 1'b0, mem[rptr].data};
      end
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH)); // R4
  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == (AW+1)'(DEPTH))); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (rd_word == 11'h100)); // R3
endmodule

// File: rtl/urx_causes.sv
module urx_causes
  import urx_pkg::*;
#(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          idle,
  input  logic          push,
  input  rx_entry_t     entry,
  input  logic          ovr_evt,
  input  logic          pop,
  input  logic [LW-1:0] level,
  input  logic [2:0]    trig_sel,
  input  logic [1:0]    tmo_sel,
  input  logic          rx_irq_en,
  input  logic          err_irq_en,
  input  logic [2:0]    err_clr,
  output logic [4:0]    cause,
  output logic          irq
);
  localparam int MAX_TMO = 16 * CHAR_TICKS;
  localparam int CW = $clog2(MAX_TMO + 1);

  logic [CW-1:0] idle_cnt, tmo_lim;
  logic [2:0]    err_set;

  always_comb begin
    case (tmo_sel)
      2'd1:    tmo_lim = CW'(4 * CHAR_TICKS);
      2'd2:    tmo_lim = CW'(8 * CHAR_TICKS);
      default: tmo_lim = CW'(MAX_TMO);
    endcase
  end

  assign err_set = {ovr_evt, push && entry.brk, push && entry.fe};

  always_ff @(posedge clk) begin
    if (rst || push || pop || !idle || (level == '0)) idle_cnt <= '0;
    else if (tick && (idle_cnt != CW'(MAX_TMO)))      idle_cnt <= idle_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause <= '0;
      irq   <= 1'b0;
    end else begin
      cause[0] <= (LW'(level) >= LW'(trig_bytes(trig_sel)));
      cause[1] <= (tmo_sel != 2'd0) && (level != '0) && !pop && (idle_cnt >= tmo_lim);
      for (int k = 0; k < 3; k++)
        cause[k+2] <= err_set[k] | (cause[k+2] & ~err_clr[k]);
      irq <= (rx_irq_en && (cause[0] || cause[1])) ||
             (err_irq_en && (|cause[4:2]));
    end
  end

  AST_W1C_FE: assert property (@(posedge clk) disable iff (rst)
    (err_clr[0] && !err_set[0]) |=> !cause[2]); // R10
  AST_TMO_DATA: assert property (@(posedge clk) disable iff (rst)
    cause[1] |-> ($past(level) != '0)); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cause == '0) |=> !irq); // R11
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import urx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_line,
  input  logic [DIV_W-1:0] rate_div,
  input  logic [2:0]       trig_sel,
  input  logic [1:0]       tmo_sel,
  input  logic             rx_irq_en,
  input  logic             err_irq_en,
  input  logic             pop,
  input  logic [2:0]       err_clr,
  output logic [10:0]      rd_word,
  output logic [7:0]       level,
  output logic [4:0]       cause,
  output logic             irq
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic          tick, idle, push, ovr_evt;
  rx_entry_t     entry;
  logic [LW-1:0] count;

  assign level = 8'(count);

  urx_sampler #(.DIV_W(DIV_W)) u_sampler (
    .clk(clk), .rst(rst), .rx_line(rx_line), .rate_div(rate_div),
    .tick(tick), .idle(idle), .push(push), .entry(entry)
  );

  urx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .entry(entry), .pop(pop),
    .rd_word(rd_word), .count(count), .ovr_evt(ovr_evt)
  );

  urx_causes #(.LW(LW)) u_causes (
    .clk(clk), .rst(rst), .tick(tick), .idle(idle), .push(push),
    .entry(entry), .ovr_evt(ovr_evt), .pop(pop), .level(count),
    .trig_sel(trig_sel), .tmo_sel(tmo_sel), .rx_irq_en(rx_irq_en),
    .err_irq_en(err_irq_en), .err_clr(err_clr), .cause(cause), .irq(irq)
  );
endmodule

// File: tb/uart_rx_fifo_tb.sv
module uart_rx_fifo_tb;
  localparam int DIV = 1;
  localparam int BT  = (DIV + 1) * 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_line = 1'b1;
  logic [7:0] rate_div = 8'(DIV);
  logic [2:0] trig_sel = 3'd0;
  logic [1:0] tmo_sel = 2'd0;
  logic rx_irq_en = 1'b0, err_irq_en = 1'b0, pop = 1'b0;
  logic [2:0] err_clr = 3'd0;
  logic [10:0] rd_word;
  logic [7:0] level;
  logic [4:0] cause;
  logic irq;

  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  uart_rx_fifo u_dut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .rate_div(rate_div),
    .trig_sel(trig_sel), .tmo_sel(tmo_sel), .rx_irq_en(rx_irq_en),
    .err_irq_en(err_irq_en), .pop(pop), .err_clr(err_clr),
    .rd_word(rd_word), .level(level), .cause(cause), .irq(irq)
  );

  // {stop bit, data, expected word}
  localparam logic [19:0] VEC [8] = '{
    {1'b1, 8'h55, 11'h055}, {1'b1, 8'hA3, 11'h0A3},
    {1'b1, 8'h00, 11'h000}, {1'b1, 8'hFF, 11'h0FF},
    {1'b1, 8'h81, 11'h081}, {1'b0, 8'h3C, 11'h23C},
    {1'b0, 8'h00, 11'h400}, {1'b1, 8'h7E, 11'h07E}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic stopb);
    @(negedge clk);
    rx_line = 1'b0; wait_clk(BT);
    for (int i = 0; i < 8; i++) begin
      rx_line = d[i]; wait_clk(BT);
    end
    rx_line = stopb; wait_clk(BT);
    rx_line = 1'b1; wait_clk(4);
  endtask

  task automatic do_pop;
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic drain;
    while (level != 8'd0) do_pop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    rst = 1'b0;
    wait_clk(1);
    // R1 reset state
    check("R1 level", level, 0);
    check("R1 cause", cause, 0);
    check("R1 irq", irq, 0);
    check("R1 rd_word", rd_word, 0);

    // R3 empty pop
    do_pop();
    check("R3 empty word", rd_word, 11'h100);
    check("R3 level", level, 0);

    // Table walk: R2, R4, R5, R6
    for (int v = 0; v < 8; v++) begin
      send(VEC[v][18:11], VEC[v][19]);
      check("R4 level after frame", level, 1);
      do_pop();
      check("R2/R5/R6 word", rd_word, VEC[v][10:0]);
      check("R4 level after pop", level, 0);
    end
    check("R5 framing cause", cause[2], 1);
    check("R6 break cause", cause[3], 1);
    check("R4 no overrun", cause[4], 0);
    // R10: zero in err_clr has no effect, one clears
    @(negedge clk); err_clr = 3'b100;
    @(negedge clk); err_clr = 3'b000; wait_clk(1);
    check("R10 zero keeps framing", cause[2], 1);
    check("R10 zero keeps break", cause[3], 1);
    @(negedge clk); err_clr = 3'b011;
    @(negedge clk); err_clr = 3'b000; wait_clk(1);
    check("R10 cleared framing", cause[2], 0);
    check("R10 cleared break", cause[3], 0);

    // R8 trigger threshold 4
    trig_sel = 3'd1;
    for (int i = 0; i < 3; i++) send(8'(i + 8'h10), 1'b1);
    wait_clk(2);
    check("R8 below threshold", cause[0], 0);
    send(8'h13, 1'b1);
    wait_clk(2);
    check("R8 at threshold", cause[0], 1);
    do_pop(); wait_clk(2);
    check("R8 below after pop", cause[0], 0);
    drain();
    trig_sel = 3'd5;

    // R9 timeout 4 characters, R11 irq
    tmo_sel = 2'd1;
    send(8'h42, 1'b1);
    wait_clk(700);
    check("R9 before window", cause[1], 0);
    wait_clk(600);
    check("R9 after window", cause[1], 1);
    rx_irq_en = 1'b1; wait_clk(3);
    check("R11 irq on timeout", irq, 1);
    rx_irq_en = 1'b0; wait_clk(3);
    check("R11 irq masked", irq, 0);
    do_pop(); wait_clk(3);
    check("R9 cleared by pop", cause[1], 0);
    check("R2 timeout byte", rd_word, 11'h042);
    tmo_sel = 2'd0;

    // R12 glitch rejection
    @(negedge clk); rx_line = 1'b0; wait_clk(6); rx_line = 1'b1;
    wait_clk(BT * 12);
    check("R12 glitch stores nothing", level, 0);

    // R7 overrun
    for (int i = 0; i < 64; i++) send(8'(i + 1), 1'b1);
    check("R4 full level", level, 64);
    check("R8 trigger at 48+", cause[0], 1);
    send(8'hEE, 1'b1);
    wait_clk(2);
    check("R7 overrun cause", cause[4], 1);
    check("R7 level kept", level, 64);
    err_irq_en = 1'b1; wait_clk(3);
    check("R11 irq on overrun", irq, 1);
    do_pop();
    check("R7 first byte kept", rd_word, 11'h001);
    for (int i = 1; i < 64; i++) do_pop();
    check("R7 last byte kept", rd_word, 11'h040);
    check("R4 drained", level, 0);
    @(negedge clk); err_clr = 3'b100;
    @(negedge clk); err_clr = 3'b000; wait_clk(3);
    check("R10 overrun cleared", cause[4], 0);
    check("R11 irq idle", irq, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule